// File: doc/BRIEF.md
# Multiword DMA Host Burst Engine

This block is the host side of a multiword DMA burst on a parallel ATA bus. When software arms it and the device raises its DMA request, the engine answers with the acknowledge. It then produces a series of read or write strobes, each moving one 16-bit word, for as long as the request stays up. Each strobe is held low for the mode's minimum assertion width. The high time between strobes is stretched so that every full cycle meets the mode's minimum cycle time. Read and write strobes have separate negation minimums, and on writes the driven data is kept stable through the following negation. The chip selects stay negated the whole time.

Words move through two ready/valid streams. Words read from the device come out on the read stream, and words for the device are taken from the write stream. Each stream has a one-word holding register. Before each strobe the engine waits until the write word is present or the read slot is empty. A burst ends when the device drops its request or the host raises `stop`. Any strobe already in progress completes first. The acknowledge is then held for the mode's hold time before it is released. All timing is counted in cycles of `clk`, whose period in nanoseconds is the parameter `CLK_NS`. The numbers below assume the default of 10.

Top module: `mdma_host_engine`

## Requirements
- R1: After reset: `dmack_n`, `dior_n` and `diow_n` are 1; `dd_oe`, `rd_valid` and `word_count` are 0; `wr_ready` is 1.
- R2: In idle, a burst starts only when `arm`=1, `dmarq`=1 and `stop`=0 are sampled together. `dmack_n` goes low at the next edge. No strobe goes low in that same edge, and a strobe is low only while `dmack_n` is low.
- R3: A strobe is low for exactly A cycles, where A = ceil(assert_ns / CLK_NS) and assert_ns is 215, 80 or 70 for modes 0, 1 and 2 (22, 8 and 7 cycles). `dir_wr`=0 selects `dior_n` and `dir_wr`=1 selects `diow_n`. The two strobes are never low together.
- R4: Between strobes the strobe stays high for at least N+1 cycles, and exactly N+1 when neither stream stalls. N is the maximum of: the negation minimum (read 50/50/25 ns, write 215/50/25 ns), ceil(cycle_ns / CLK_NS) − A with cycle_ns = 480/150/120, and, on writes only, the data hold (20/15/10 ns). All ns values are rounded up to cycles.
- R5: `cs_n` is 2'b11 at all times.
- R6: On a write, `dd_out` carries the next word taken from the write stream from the edge where `diow_n` falls until the edge where it rises. `dd_oe` is 1 from the first write strobe until `dmack_n` is released.
- R7: On a read, `dd_in` is sampled at the edge where `dior_n` rises. At that same edge it appears on `rd_data` with `rd_valid`=1, and it stays there until `rd_ready`=1 is sampled.
- R8: When `dmarq`=0 or `stop`=1 is sampled between strobes, no further strobe starts. `dmack_n` rises H cycles later, where H = max(1, ceil(hold_ns / CLK_NS)) and hold_ns is 20, 5 or 5. A strobe already low runs to its full width first.
- R9: A write strobe starts only when a word is held from the write stream (`wr_ready`=0 while one is held). A read strobe starts only when the read slot is empty (`rd_valid`=0).
- R10: `word_count` is cleared when a burst starts, increments by one at each strobe rise, and holds its value after the burst.
- R11: The mode is latched when the burst starts. `mode_sel`=3 behaves as mode 2, and changing `mode_sel` during a burst has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Permits a burst to start |
| stop | input | 1 | Host request to end the burst after the current strobe |
| dir_wr | input | 1 | 1: host to device, 0: device to host |
| mode_sel | input | 2 | Multiword DMA mode 0..2 (3 acts as 2) |
| dmarq | input | 1 | Device DMA request |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cs_n | output | 2 | Chip selects, held negated |
| dd_in | input | 16 | Data bus from the device |
| dd_out | output | 16 | Data bus to the device |
| dd_oe | output | 1 | Drive enable for dd_out |
| wr_data | input | 16 | Write stream word |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| rd_data | output | 16 | Read stream word |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| word_count | output | 16 | Words moved in the current or last burst |

## Verification
`dmack_n` falls one edge after the start condition is sampled. The first strobe falls no earlier than the edge after that. `rd_valid` rises on the same edge as `dior_n`, and `dmack_n` rises H edges after the end request is seen between strobes. The bench steps a behavioural model on each rising edge, using the same input values the design samples, and compares every output against it at the following falling edge. Inputs change one nanosecond after a rising edge, so each result is read exactly in the cycle in which it is due. Strobe widths, inter-strobe gaps, stall holds and the data carried are also measured directly from the pins and checked against the cycle counts derived in R3 and R4.

// File: rtl/mdma_pkg.sv
`timescale 1ns/1ps
package mdma_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GAP,
    PH_ASRT,
    PH_NEG,
    PH_HOLD
  } phase_t;

  function automatic int unsigned cdiv(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned maxu(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Mode timing in ns; any index above 2 uses the mode 2 figures.
  function automatic int unsigned ns_cycle(input int unsigned m);
    case (m)
      0: return 480;
      1: return 150;
      default: return 120;
    endcase
  endfunction

  function automatic int unsigned ns_assert(input int unsigned m);
    case (m)
      0: return 215;
      1: return 80;
      default: return 70;
    endcase
  endfunction

  function automatic int unsigned ns_neg_rd(input int unsigned m);
    case (m)
      0: return 50;
      1: return 50;
      default: return 25;
    endcase
  endfunction

  function automatic int unsigned ns_neg_wr(input int unsigned m);
    case (m)
      0: return 215;
      1: return 50;
      default: return 25;
    endcase
  endfunction

  function automatic int unsigned ns_data_hold(input int unsigned m);
    case (m)
      0: return 20;
      1: return 15;
      default: return 10;
    endcase
  endfunction

  function automatic int unsigned ns_ack_hold(input int unsigned m);
    case (m)
      0: return 20;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/mdma_timing.sv
`timescale 1ns/1ps
module mdma_timing
  import mdma_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int CW     = 8,
  parameter int MW     = 2
) (
  input  logic [MW-1:0] mode,
  output logic [CW-1:0] asrt_cyc,
  output logic [CW-1:0] negr_cyc,
  output logic [CW-1:0] negw_cyc,
  output logic [CW-1:0] hold_cyc
);

  localparam int NMODES = 1 << MW;

  logic [CW-1:0] t_asrt [NMODES];
  logic [CW-1:0] t_negr [NMODES];
  logic [CW-1:0] t_negw [NMODES];
  logic [CW-1:0] t_hold [NMODES];

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    localparam int unsigned A    = maxu(cdiv(ns_assert(m), CLK_NS), 1);
    localparam int unsigned C    = cdiv(ns_cycle(m), CLK_NS);
    localparam int unsigned REST = (C > A) ? (C - A) : 1;
    localparam int unsigned NR   = maxu(maxu(cdiv(ns_neg_rd(m), CLK_NS), REST), 1);
    localparam int unsigned NW   = maxu(maxu(cdiv(ns_neg_wr(m), CLK_NS), REST),
                                        cdiv(ns_data_hold(m), CLK_NS));
    localparam int unsigned H    = maxu(cdiv(ns_ack_hold(m), CLK_NS), 1);
    assign t_asrt[m] = CW'(A);
    assign t_negr[m] = CW'(NR);
    assign t_negw[m] = CW'(NW);
    assign t_hold[m] = CW'(H);
  end

  always_comb begin
    asrt_cyc = t_asrt[mode];
    negr_cyc = t_negr[mode];
    negw_cyc = t_negw[mode];
    hold_cyc = t_hold[mode];
  end

endmodule

// File: rtl/mdma_word_slot.sv
`timescale 1ns/1ps
module mdma_word_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic          full_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!full_q && in_valid) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end else if (full_q && out_ready) begin
      full_q <= 1'b0;
    end
  end

  assign in_ready  = ~full_q;
  assign out_valid = full_q;
  assign out_data  = data_q;

endmodule

// File: rtl/mdma_burst_fsm.sv
`timescale 1ns/1ps
module mdma_burst_fsm
  import mdma_pkg::*;
#(
  parameter int DW  = 16,
  parameter int CW  = 8,
  parameter int WCW = 16,
  parameter int MW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           arm,
  input  logic           stop,
  input  logic           dmarq,
  input  logic           dir_wr,
  input  logic [MW-1:0]  mode_in,
  output logic [MW-1:0]  mode_q,
  input  logic [CW-1:0]  asrt_cyc,
  input  logic [CW-1:0]  negr_cyc,
  input  logic [CW-1:0]  negw_cyc,
  input  logic [CW-1:0]  hold_cyc,
  input  logic           tx_avail,
  input  logic [DW-1:0]  tx_word,
  output logic           tx_take,
  input  logic           rx_space,
  output logic           rx_put,
  output logic           dmack_n,
  output logic           dior_n,
  output logic           diow_n,
  output logic           dd_oe,
  output logic [DW-1:0]  dd_out,
  output logic [WCW-1:0] word_count
);

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic          end_req;
  logic          go;

  assign end_req = ~dmarq | stop;
  assign go      = wr_q ? tx_avail : rx_space;
  assign tx_take = (ph == PH_GAP) && !end_req && wr_q && tx_avail;
  assign rx_put  = (ph == PH_ASRT) && (cnt == '0) && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      cnt        <= '0;
      wr_q       <= 1'b0;
      mode_q     <= '0;
      dmack_n    <= 1'b1;
      dior_n     <= 1'b1;
      diow_n     <= 1'b1;
      dd_oe      <= 1'b0;
      dd_out     <= '0;
      word_count <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (arm && dmarq && !stop) begin
            ph         <= PH_GAP;
            dmack_n    <= 1'b0;
            mode_q     <= mode_in;
            wr_q       <= dir_wr;
            word_count <= '0;
          end
        end
        PH_GAP: begin
          if (end_req) begin
            ph  <= PH_HOLD;
            cnt <= hold_cyc - 1'b1;
          end else if (go) begin
            ph  <= PH_ASRT;
            cnt <= asrt_cyc - 1'b1;
            if (wr_q) begin
              diow_n <= 1'b0;
              dd_out <= tx_word;
              dd_oe  <= 1'b1;
            end else begin
              dior_n <= 1'b0;
            end
          end
        end
        PH_ASRT: begin
          if (cnt == '0) begin
            ph         <= PH_NEG;
            dior_n     <= 1'b1;
            diow_n     <= 1'b1;
            word_count <= word_count + 1'b1;
            cnt        <= (wr_q ? negw_cyc : negr_cyc) - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_NEG: begin
          if (cnt == '0) ph <= PH_GAP;
          else           cnt <= cnt - 1'b1;
        end
        PH_HOLD: begin
          if (cnt == '0) begin
            ph      <= PH_IDLE;
            dmack_n <= 1'b1;
            dd_oe   <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdma_host_engine.sv
`timescale 1ns/1ps
module mdma_host_engine #(
  parameter int CLK_NS = 10,
  parameter int DW     = 16,
  parameter int CW     = 8,
  parameter int WCW    = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           arm,
  input  logic           stop,
  input  logic           dir_wr,
  input  logic [1:0]     mode_sel,
  input  logic           dmarq,
  output logic           dmack_n,
  output logic           dior_n,
  output logic           diow_n,
  output logic [1:0]     cs_n,
  input  logic [DW-1:0]  dd_in,
  output logic [DW-1:0]  dd_out,
  output logic           dd_oe,
  input  logic [DW-1:0]  wr_data,
  input  logic           wr_valid,
  output logic           wr_ready,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [WCW-1:0] word_count
);

  localparam int MW = 2;

  logic [MW-1:0] mode_q;
  logic [CW-1:0] asrt_cyc, negr_cyc, negw_cyc, hold_cyc;
  logic          tx_avail, tx_take;
  logic [DW-1:0] tx_word;
  logic          rx_space, rx_put;

  // Chip selects stay negated: this block only runs DMA cycles.
  assign cs_n = 2'b11;

  mdma_timing #(.CLK_NS(CLK_NS), .CW(CW), .MW(MW)) u_timing (
    .mode     (mode_q),
    .asrt_cyc (asrt_cyc),
    .negr_cyc (negr_cyc),
    .negw_cyc (negw_cyc),
    .hold_cyc (hold_cyc)
  );

  mdma_word_slot #(.DW(DW)) u_tx_slot (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .in_data   (wr_data),
    .out_valid (tx_avail),
    .out_ready (tx_take),
    .out_data  (tx_word)
  );

  mdma_word_slot #(.DW(DW)) u_rx_slot (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rx_put),
    .in_ready  (rx_space),
    .in_data   (dd_in),
    .out_valid (rd_valid),
    .out_ready (rd_ready),
    .out_data  (rd_data)
  );

  mdma_burst_fsm #(.DW(DW), .CW(CW), .WCW(WCW), .MW(MW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .stop       (stop),
    .dmarq      (dmarq),
    .dir_wr     (dir_wr),
    .mode_in    (mode_sel),
    .mode_q     (mode_q),
    .asrt_cyc   (asrt_cyc),
    .negr_cyc   (negr_cyc),
    .negw_cyc   (negw_cyc),
    .hold_cyc   (hold_cyc),
    .tx_avail   (tx_avail),
    .tx_word    (tx_word),
    .tx_take    (tx_take),
    .rx_space   (rx_space),
    .rx_put     (rx_put),
    .dmack_n    (dmack_n),
    .dior_n     (dior_n),
    .diow_n     (diow_n),
    .dd_oe      (dd_oe),
    .dd_out     (dd_out),
    .word_count (word_count)
  );

endmodule

// File: rtl/mdma_host_engine_chk.sv
`timescale 1ns/1ps
module mdma_host_engine_chk #(
  parameter int WCW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           dmack_n,
  input logic           dior_n,
  input logic           diow_n,
  input logic           dd_oe,
  input logic           rd_valid,
  input logic [WCW-1:0] word_count
);

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n));

  assert_strobe_in_ack_R2: assert property (@(posedge clk) disable iff (rst)
    (!dior_n || !diow_n) |-> !dmack_n);

  assert_release_after_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(dmack_n) |-> ($past(dior_n) && $past(diow_n) && dior_n && diow_n));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    ($rose(dior_n) || $rose(diow_n)) |-> (word_count == WCW'($past(word_count) + 1'b1)));

  assert_read_lands_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(dior_n) |-> rd_valid);

  assert_drive_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    !diow_n |-> dd_oe);

endmodule

bind mdma_host_engine mdma_host_engine_chk #(.WCW(WCW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dmack_n    (dmack_n),
  .dior_n     (dior_n),
  .diow_n     (diow_n),
  .dd_oe      (dd_oe),
  .rd_valid   (rd_valid),
  .word_count (word_count)
);

// File: tb/mdma_host_engine_test.sv
`timescale 1ns/1ps
module mdma_host_engine_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0, stop = 1'b0, dir_wr = 1'b0, dmarq = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        dmack_n, dior_n, diow_n, dd_oe, wr_ready, rd_valid;
  logic [1:0]  cs_n;
  logic [15:0] dd_in, dd_out, wr_data, rd_data, word_count;
  logic        wr_valid, rd_ready;

  int checks = 0, errors = 0, cyc = 0;
  bit wv_en = 0, wv_gap = 0, rr_en = 1, rr_gap = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdma_host_engine #(.CLK_NS(CLK_PERIOD)) uut (
    .clk(clk), .rst(rst), .arm(arm), .stop(stop), .dir_wr(dir_wr),
    .mode_sel(mode_sel), .dmarq(dmarq), .dmack_n(dmack_n), .dior_n(dior_n),
    .diow_n(diow_n), .cs_n(cs_n), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .word_count(word_count)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---- timing expectations derived from the requirement tables ----
  function automatic int up(input int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int e_asrt(input int m);
    int t[3] = '{215, 80, 70};
    return mx(up(t[m]), 1);
  endfunction
  function automatic int e_neg(input int m, input bit w);
    int cy[3] = '{480, 150, 120};
    int nr[3] = '{50, 50, 25};
    int nw[3] = '{215, 50, 25};
    int dh[3] = '{20, 15, 10};
    int rest;
    rest = up(cy[m]) - e_asrt(m);
    if (rest < 1) rest = 1;
    return w ? mx(mx(up(nw[m]), rest), up(dh[m])) : mx(mx(up(nr[m]), rest), 1);
  endfunction
  function automatic int e_hold(input int m);
    int t[3] = '{20, 5, 5};
    return mx(up(t[m]), 1);
  endfunction

  // ---- behavioural reference model, stepped on each rising edge ----
  int   m_ph, m_cnt, m_mode, m_wc, m_txcnt, m_rdcnt;
  bit   m_wr, m_dmack_n, m_dior_n, m_diow_n, m_oe, m_txf, m_rxf;
  logic [15:0] m_dout, m_txw, m_rxw;

  assign wr_data  = 16'hA500 + 16'(m_txcnt);
  assign dd_in    = 16'h3C00 + 16'(m_rdcnt * 3);
  assign wr_valid = wv_en && !(wv_gap && (cyc % 3 == 0));
  assign rd_ready = rr_en && !(rr_gap && (cyc % 4 == 0));

  always @(posedge clk) begin : model
    bit endr, take, put;
    if (rst) begin
      m_ph <= 0; m_cnt <= 0; m_mode <= 0; m_wc <= 0; m_txcnt <= 0; m_rdcnt <= 0;
      m_wr <= 0; m_dmack_n <= 1; m_dior_n <= 1; m_diow_n <= 1; m_oe <= 0;
      m_txf <= 0; m_rxf <= 0; m_dout <= '0; m_txw <= '0; m_rxw <= '0;
    end else begin
      endr = !dmarq || stop;
      take = (m_ph == 1) && !endr && m_wr && m_txf;
      put  = (m_ph == 2) && (m_cnt == 0) && !m_wr;
      if (!m_txf && wr_valid) begin
        m_txf <= 1; m_txw <= wr_data; m_txcnt <= m_txcnt + 1;
      end else if (take) m_txf <= 0;
      if (put) begin
        m_rxf <= 1; m_rxw <= dd_in; m_rdcnt <= m_rdcnt + 1;
      end else if (m_rxf && rd_ready) m_rxf <= 0;
      case (m_ph)
        0: if (arm && dmarq && !stop) begin
             m_ph <= 1; m_dmack_n <= 0; m_wr <= dir_wr; m_wc <= 0;
             m_mode <= (mode_sel > 2) ? 2 : int'(mode_sel);
           end
        1: if (endr) begin
             m_ph <= 4; m_cnt <= e_hold(m_mode) - 1;
           end else if (m_wr ? m_txf : !m_rxf) begin
             m_ph <= 2; m_cnt <= e_asrt(m_mode) - 1;
             if (m_wr) begin m_diow_n <= 0; m_dout <= m_txw; m_oe <= 1; end
             else m_dior_n <= 0;
           end
        2: if (m_cnt == 0) begin
             m_ph <= 3; m_dior_n <= 1; m_diow_n <= 1; m_wc <= m_wc + 1;
             m_cnt <= e_neg(m_mode, m_wr) - 1;
           end else m_cnt <= m_cnt - 1;
        3: if (m_cnt == 0) m_ph <= 1; else m_cnt <= m_cnt - 1;
        4: if (m_cnt == 0) begin m_ph <= 0; m_dmack_n <= 1; m_oe <= 0; end
           else m_cnt <= m_cnt - 1;
        default: ;
      endcase
    end
  end

  // ---- cycle compare against the model, away from the active edge ----
  always @(negedge clk) begin
    if (!rst) begin
      chk(dmack_n === m_dmack_n, "R2/R8 dmack_n", 32'(dmack_n), 32'(m_dmack_n));
      chk(dior_n === m_dior_n, "R3/R4 dior_n", 32'(dior_n), 32'(m_dior_n));
      chk(diow_n === m_diow_n, "R3/R4 diow_n", 32'(diow_n), 32'(m_diow_n));
      chk(dd_oe === m_oe, "R6 dd_oe", 32'(dd_oe), 32'(m_oe));
      if (m_oe) chk(dd_out === m_dout, "R6 dd_out", 32'(dd_out), 32'(m_dout));
      chk(rd_valid === m_rxf, "R7/R9 rd_valid", 32'(rd_valid), 32'(m_rxf));
      if (m_rxf) chk(rd_data === m_rxw, "R7 rd_data", 32'(rd_data), 32'(m_rxw));
      chk(wr_ready === !m_txf, "R9 wr_ready", 32'(wr_ready), 32'(!m_txf));
      chk(word_count === 16'(m_wc), "R10 word_count", 32'(word_count), 32'(m_wc));
      chk(cs_n === 2'b11, "R5 cs_n", 32'(cs_n), 32'h3);
    end
  end

  // ---- pin monitors: strobe width, gap, written and read words ----
  int lowcnt = 0, hicnt = 0, last_w = 0, last_gap = 0, widx = 0, ridx = 0;
  bit wasw = 0;
  logic [15:0] dlast;
  always @(posedge clk) begin
    if (rst) begin
      lowcnt = 0; hicnt = 0;
    end else begin
      if (!dior_n || !diow_n) begin
        if (lowcnt == 0) last_gap = hicnt;
        hicnt = 0; lowcnt++;
        wasw = !diow_n;
        if (!diow_n) dlast = dd_out;
      end else begin
        if (lowcnt > 0) begin
          last_w = lowcnt;
          if (wasw) begin
            chk(dlast === 16'hA500 + 16'(widx), "R6 written word", 32'(dlast),
                32'(16'hA500 + 16'(widx)));
            widx++;
          end
        end
        lowcnt = 0;
        if (!dmack_n) hicnt++; else hicnt = 0;
      end
      if (rd_valid && rd_ready) begin
        chk(rd_data === 16'h3C00 + 16'(ridx * 3), "R7 read word", 32'(rd_data),
            32'(16'h3C00 + 16'(ridx * 3)));
        ridx++;
      end
    end
  end

  // ---- scenario helpers ----
  task automatic start_burst(input int m, input bit w);
    @(posedge clk); #1;
    mode_sel = 2'(m); dir_wr = w; arm = 1; dmarq = 1;
  endtask
  task automatic wait_words(input int n);
    do begin @(posedge clk); #1; end while (m_wc < n);
  endtask
  task automatic end_burst(input bit by_stop);
    if (by_stop) stop = 1; else dmarq = 0;
    do begin @(posedge clk); #1; end while (m_ph != 0);
    arm = 0; stop = 0; dmarq = 0; wv_gap = 0; rr_gap = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(dmack_n && dior_n && diow_n, "R1 bus idle", {dmack_n, dior_n, diow_n}, 3'b111);
    chk(!dd_oe && !rd_valid && wr_ready, "R1 streams", {dd_oe, rd_valid, wr_ready}, 3'b001);
    chk(word_count === 16'd0, "R1 word_count", 32'(word_count), 0);

    // R2: no start while stop is high, nor without arm
    @(posedge clk); #1; dmarq = 1; stop = 1; arm = 1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(dmack_n === 1'b1, "R2 stop blocks start", 32'(dmack_n), 1);
    @(posedge clk); #1; stop = 0; arm = 0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(dmack_n === 1'b1, "R2 arm needed", 32'(dmack_n), 1);
    @(posedge clk); #1; dmarq = 0;

    // Write, mode 0: starved write stream first (R9), then 3 words, device ends
    wv_en = 0;
    start_burst(0, 1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(!dmack_n && diow_n, "R9 write stalls without a word", {dmack_n, diow_n}, 2'b01);
    @(posedge clk); #1; wv_en = 1;
    wait_words(3);
    end_burst(0);
    chk(word_count === 16'd3, "R10 count after write burst", 32'(word_count), 3);
    chk(last_w == e_asrt(0), "R3 mode 0 strobe width", last_w, e_asrt(0));
    chk(last_gap == e_neg(0, 1) + 1, "R4 mode 0 write gap", last_gap, e_neg(0, 1) + 1);
    chk(widx == 3, "R6 words written", widx, 3);

    // Read, mode 1: full read slot stalls (R9), then 4 words, host stop
    wv_en = 0; rr_en = 0;
    start_burst(1, 0);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk(word_count === 16'd1 && dior_n && rd_valid, "R9 read stalls on full slot",
        {word_count[3:0], dior_n, rd_valid}, {4'd1, 2'b11});
    @(posedge clk); #1; rr_en = 1;
    wait_words(4);
    end_burst(1);
    chk(word_count === 16'd4, "R10 count after read burst", 32'(word_count), 4);
    chk(last_w == e_asrt(1), "R3 mode 1 strobe width", last_w, e_asrt(1));
    chk(last_gap == e_neg(1, 0) + 1, "R4 mode 1 read gap", last_gap, e_neg(1, 0) + 1);

    // Write, mode 2 with a gappy write stream, host stop
    wv_en = 1; wv_gap = 1;
    start_burst(2, 1);
    wv_gap = 1;
    wait_words(5);
    end_burst(1);
    chk(word_count === 16'd5, "R10 count after gappy write", 32'(word_count), 5);
    chk(last_w == e_asrt(2), "R3 mode 2 strobe width", last_w, e_asrt(2));
    chk(widx == 8, "R6 words written total", widx, 8);

    // Read, mode 3 acts as mode 2; mode_sel change mid-burst ignored (R11)
    wv_en = 0;
    start_burst(3, 0);
    wait_words(1);
    mode_sel = 2'd0;
    wait_words(4);
    end_burst(0);
    chk(last_w == e_asrt(2), "R11 mode 3 latched as mode 2 width", last_w, e_asrt(2));
    chk(last_gap == e_neg(2, 0) + 1, "R11/R4 mode 2 read gap", last_gap, e_neg(2, 0) + 1);
    chk(word_count === 16'd4, "R10 count held after burst", 32'(word_count), 4);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ridx == 8, "R7 words read total", ridx, 8);
    chk(dmack_n && !dd_oe, "R8 released after end", {dmack_n, dd_oe}, 2'b10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule